// File: doc/BRIEF.md
# Reset Origin Classifier

This block finds where a chip reset came from when internal and external sources share one open-drain reset pin. An internal source is the watchdog or the clock-loss detector. When it raises a request, the block pulls the shared pin low for a fixed number of E-clock cycles and then lets go. After a fixed settling delay it reads the pin once. If the pin has come back high, the request was the only thing holding it low, so the reset is recorded as internal and the latched cause is kept. If the pin is still low, something outside is also holding it, so the reset is recorded as external and the cause code is cleared.

A low level on the pin with no internal request pending skips the drive phase and goes straight to the external path. The held chip reset output stays asserted from the start of any reset until the synchronized pin is seen high after classification. The pin and the request lines are plain control signals, so there is no valid/ready handshake and nothing applies back-pressure. Requests that arrive while a reset is in progress are dropped.

Top module: `reset_origin_classifier`

## Requirements
- R1: After the asynchronous block reset, `pin_pull`, `chip_rst` and `ext_flag` are 0 and `cause_code` is 2'b00.
- R2: A request accepted while idle makes `pin_pull` 1 from the next cycle for exactly DRIVE_CYC (default 16) consecutive cycles. `chip_rst` rises in the same cycle as `pin_pull`.
- R3: The pin level passes through a two-flop synchronizer before any use. An external low applied while idle raises `chip_rst` on the third rising edge after the pin changes.
- R4: The synchronized pin is sampled once, SETTLE_CYC (default 8) cycles after `pin_pull` drops. If the sample is high, `chip_rst` falls on that sampling edge, `ext_flag` is 0 and `cause_code` keeps the latched cause.
- R5: If that sample is low, `ext_flag` becomes 1 and `cause_code` becomes 2'b00. `chip_rst` then stays 1 until the synchronized pin reads high.
- R6: An external low that starts together with an internal request and lasts at least 32 cycles is classified as external, never as watchdog or clock-monitor.
- R7: `chip_rst` stays 1 for the whole reset, from its first cycle to its release, with no gap.
- R8: A synchronized low pin with no request pending enters the external path without ever asserting `pin_pull`: `ext_flag` becomes 1 and `cause_code` becomes 2'b00.
- R9: A request that arrives while `chip_rst` is 1 is ignored. It neither changes `cause_code` nor lengthens or restarts the pull.
- R10: The cause of an accepted request is latched from `int_cause`, where 2'b01 means watchdog and 2'b10 means clock monitor.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | E-clock |
| arst_n | input | 1 | Asynchronous active-low block reset |
| pin_in | input | 1 | Raw level of the shared reset pin |
| int_req | input | 1 | Internal reset request from the watchdog or the clock monitor |
| int_cause | input | 2 | Cause of the request: 01 watchdog, 10 clock monitor |
| pin_pull | output | 1 | Enable for the open-drain pull-down on the pin |
| chip_rst | output | 1 | Held chip-wide reset |
| ext_flag | output | 1 | 1 when the last reset was classified as external |
| cause_code | output | 2 | Internal cause of the last reset, 00 after an external one |

## Verification
Several properties are checked on every cycle: every pull burst lasts exactly DRIVE_CYC cycles; the latched cause cannot change while the pin is being driven; an external classification always comes with a cleared cause; the held reset is released only after a high synchronized pin; and an idle low pin always enters the external path without a pull. Other behaviour can only be shown by the bench's scenarios, because it depends on how the outside world holds the pin: the settle length, the synchronizer latency, the 32-cycle overlap with a request, dropping requests in the middle of a reset, and keeping the cause across classifications.

// File: rtl/rdisc_pkg.sv
package rdisc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DRIVE  = 2'd1,
    ST_SETTLE = 2'd2,
    ST_HOLD   = 2'd3
  } rdisc_state_e;

  localparam logic [1:0] CAUSE_NONE   = 2'b00;
  localparam logic [1:0] CAUSE_WDOG   = 2'b01;
  localparam logic [1:0] CAUSE_CLKMON = 2'b10;

endpackage

// File: rtl/rdisc_sync.sv
module rdisc_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic arst_n,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain_q;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[0] <= RST_VAL;
          else         chain_q[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge arst_n) begin
          if (!arst_n) chain_q[i] <= RST_VAL;
          else         chain_q[i] <= chain_q[i-1];
        end
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/rdisc_timer.sv
module rdisc_timer #(
  parameter  int MAX_LOAD = 16,
  localparam int W        = $clog2(MAX_LOAD + 1)
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)        cnt_q <= '0;
    else if (load)      cnt_q <= load_val;
    else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // R2: the count never runs above the longest phase length
  assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!arst_n)
    cnt_q <= W'(MAX_LOAD));

endmodule

// File: rtl/rdisc_ctrl.sv
module rdisc_ctrl
  import rdisc_pkg::*;
#(
  parameter int DRIVE_CYC = 16,
  parameter int SETTLE_CYC = 8,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             pin_s,
  input  logic             int_req,
  input  logic [1:0]       int_cause,
  input  logic             tmr_zero,
  output logic             tmr_load,
  output logic [CNT_W-1:0] tmr_val,
  output logic             pin_pull,
  output logic             chip_rst,
  output logic             ext_flag,
  output logic [1:0]       cause_code
);

  rdisc_state_e state_q, state_d;
  logic         ext_q, ext_d;
  logic [1:0]   cause_q, cause_d;

  always_comb begin
    state_d  = state_q;
    ext_d    = ext_q;
    cause_d  = cause_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (int_req) begin
          state_d  = ST_DRIVE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(DRIVE_CYC - 1);
          ext_d    = 1'b0;
          cause_d  = int_cause;
        end else if (!pin_s) begin
          state_d = ST_HOLD;
          ext_d   = 1'b1;
          cause_d = CAUSE_NONE;
        end
      end
      ST_DRIVE: begin
        if (tmr_zero) begin
          state_d  = ST_SETTLE;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(SETTLE_CYC - 1);
        end
      end
      ST_SETTLE: begin
        if (tmr_zero) begin
          if (pin_s) begin
            state_d = ST_IDLE;
          end else begin
            state_d = ST_HOLD;
            ext_d   = 1'b1;
            cause_d = CAUSE_NONE;
          end
        end
      end
      ST_HOLD: begin
        if (pin_s) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      ext_q   <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else begin
      state_q <= state_d;
      ext_q   <= ext_d;
      cause_q <= cause_d;
    end
  end

  assign pin_pull   = (state_q == ST_DRIVE);
  assign chip_rst   = (state_q != ST_IDLE);
  assign ext_flag   = ext_q;
  assign cause_code = cause_q;

  // checker-only run length of the pull burst
  logic [CNT_W:0] pull_run_q;
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)       pull_run_q <= '0;
    else if (pin_pull) pull_run_q <= pull_run_q + 1'b1;
    else               pull_run_q <= '0;
  end

  // R2: every pull burst ends after exactly DRIVE_CYC cycles
  assert_pull_len_R2: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(pin_pull) |-> (pull_run_q == (CNT_W+1)'(DRIVE_CYC)));

  // R9: the latched cause is frozen while the pin is being driven
  assert_cause_frozen_R9: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_DRIVE) |=> $stable(cause_q));

  // R5: an external classification always clears the cause
  assert_ext_clears_R5: assert property (@(posedge clk) disable iff (!arst_n)
    $rose(ext_q) |-> (cause_q == CAUSE_NONE));

  // R4: the held reset is released only after a high synchronized pin
  assert_release_high_R4: assert property (@(posedge clk) disable iff (!arst_n)
    $fell(chip_rst) |-> $past(pin_s));

endmodule

// File: rtl/reset_origin_classifier.sv
module reset_origin_classifier #(
  parameter int DRIVE_CYC   = 16,
  parameter int SETTLE_CYC  = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       arst_n,
  input  logic       pin_in,
  input  logic       int_req,
  input  logic [1:0] int_cause,
  output logic       pin_pull,
  output logic       chip_rst,
  output logic       ext_flag,
  output logic [1:0] cause_code
);

  localparam int MAX_LOAD = (DRIVE_CYC > SETTLE_CYC) ? DRIVE_CYC : SETTLE_CYC;
  localparam int CNT_W    = $clog2(MAX_LOAD + 1);

  logic             pin_s;
  logic             tmr_load;
  logic             tmr_zero;
  logic [CNT_W-1:0] tmr_val;

  rdisc_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
    .clk    (clk),
    .arst_n (arst_n),
    .d      (pin_in),
    .q      (pin_s)
  );

  rdisc_timer #(.MAX_LOAD(MAX_LOAD)) u_timer (
    .clk      (clk),
    .arst_n   (arst_n),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  rdisc_ctrl #(
    .DRIVE_CYC  (DRIVE_CYC),
    .SETTLE_CYC (SETTLE_CYC),
    .CNT_W      (CNT_W)
  ) u_ctrl (
    .clk        (clk),
    .arst_n     (arst_n),
    .pin_s      (pin_s),
    .int_req    (int_req),
    .int_cause  (int_cause),
    .tmr_zero   (tmr_zero),
    .tmr_load   (tmr_load),
    .tmr_val    (tmr_val),
    .pin_pull   (pin_pull),
    .chip_rst   (chip_rst),
    .ext_flag   (ext_flag),
    .cause_code (cause_code)
  );

  // R8: an idle low pin with no request enters the external path undriven
  assert_direct_ext_R8: assert property (@(posedge clk) disable iff (!arst_n)
    (!chip_rst && !int_req && !pin_s) |=> (chip_rst && !pin_pull && ext_flag));

endmodule

// File: tb/reset_origin_classifier_test.sv
module reset_origin_classifier_test;

  typedef struct packed {
    logic       ext;
    logic [1:0] cause;
    logic [7:0] pull;
    logic [7:0] settle;
  } exp_t;

  logic       clk = 1'b0;
  logic       arst_n = 1'b0;
  logic       int_req = 1'b0;
  logic [1:0] int_cause = 2'b00;
  logic       ext_low = 1'b0;
  logic       pin_in;
  logic       pin_pull, chip_rst, ext_flag;
  logic [1:0] cause_code;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  exp_t  exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  assign pin_in = !(pin_pull || ext_low);

  reset_origin_classifier uut (
    .clk(clk), .arst_n(arst_n), .pin_in(pin_in), .int_req(int_req),
    .int_cause(int_cause), .pin_pull(pin_pull), .chip_rst(chip_rst),
    .ext_flag(ext_flag), .cause_code(cause_code)
  );

  task automatic check(input bit ok, input string tag, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, expv);
    end
  endtask

  task automatic push(input logic ext, input logic [1:0] cause,
                      input int pull, input int settle, input string tag);
    exp_t e;
    e.ext = ext; e.cause = cause; e.pull = 8'(pull); e.settle = 8'(settle);
    exp_q.push_back(e);
    tag_q.push_back(tag);
  endtask

  task automatic request(input logic [1:0] c);
    int_req = 1'b1; int_cause = c;
    @(negedge clk);
    int_req = 1'b0; int_cause = 2'b00;
  endtask

  // monitor: measures each reset episode and compares with the scoreboard
  bit mon_on = 1'b0;
  bit prev_rst = 1'b0;
  bit m_seen = 1'b0;
  int m_pull = 0, m_settle = 0, m_lead = 0;

  always @(negedge clk) begin
    if (mon_on) begin
      if (chip_rst && !prev_rst) begin
        m_pull = 0; m_settle = 0; m_lead = 0; m_seen = 1'b0;
      end
      if (chip_rst) begin
        if (pin_pull) begin m_pull++; m_seen = 1'b1; end
        else if (m_seen) m_settle++;
        else m_lead++;
      end
      if (!chip_rst && prev_rst) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "unexpected reset episode", m_pull, 0);
        end else begin
          exp_t e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          check(ext_flag == e.ext, {t, " ext_flag"}, ext_flag, e.ext);
          check(cause_code == e.cause, {t, " cause_code"}, cause_code, e.cause);
          check(m_pull == int'(e.pull), {t, " pull length"}, m_pull, e.pull);
          if (e.pull != 0)
            check(m_lead == 0, {t, " R7 chip_rst vs pull start"}, m_lead, 0);
          if (!e.ext)
            check(m_settle == int'(e.settle), {t, " settle length"}, m_settle, e.settle);
        end
      end
      prev_rst = chip_rst;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(pin_pull == 1'b0, "R1 pin_pull", pin_pull, 0);
    check(chip_rst == 1'b0, "R1 chip_rst", chip_rst, 0);
    check(ext_flag == 1'b0, "R1 ext_flag", ext_flag, 0);
    check(cause_code == 2'b00, "R1 cause_code", cause_code, 0);
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    mon_on = 1'b1;

    // R2 R4 R10: watchdog request, pin returns high
    push(1'b0, 2'b01, 16, 8, "R2 R4 R10 watchdog");
    request(2'b01);
    repeat (40) @(negedge clk);

    // R10: clock-monitor request
    push(1'b0, 2'b10, 16, 8, "R10 clock monitor");
    request(2'b10);
    repeat (40) @(negedge clk);

    // R9: second request mid-drive is dropped
    push(1'b0, 2'b01, 16, 8, "R9 request during drive");
    request(2'b01);
    repeat (5) @(negedge clk);
    request(2'b10);
    repeat (40) @(negedge clk);
    check(chip_rst == 1'b0, "R9 no restart", chip_rst, 0);
    check(cause_code == 2'b01, "R9 cause kept", cause_code, 1);

    // R6 R5: external held 32 cycles starting with a request
    push(1'b1, 2'b00, 16, 0, "R6 R5 overlap external");
    ext_low = 1'b1;
    request(2'b01);
    repeat (31) @(negedge clk);
    ext_low = 1'b0;
    repeat (30) @(negedge clk);
    check(ext_flag == 1'b1, "R5 ext_flag held", ext_flag, 1);
    check(cause_code == 2'b00, "R5 cause cleared", cause_code, 0);

    // R3 R8 R9: direct external low, request ignored during it
    push(1'b1, 2'b00, 0, 0, "R8 R9 direct external");
    ext_low = 1'b1;
    @(negedge clk);
    check(chip_rst == 1'b0, "R3 sync delay 1", chip_rst, 0);
    @(negedge clk);
    check(chip_rst == 1'b0, "R3 sync delay 2", chip_rst, 0);
    @(negedge clk);
    check(chip_rst == 1'b1, "R3 rise at third edge", chip_rst, 1);
    repeat (3) @(negedge clk);
    request(2'b10);
    repeat (15) @(negedge clk);
    check(chip_rst == 1'b1, "R5 held while pin low", chip_rst, 1);
    check(pin_pull == 1'b0, "R8 no pull", pin_pull, 0);
    ext_low = 1'b0;
    repeat (10) @(negedge clk);
    check(chip_rst == 1'b0, "R5 release after pin high", chip_rst, 0);

    // R4 R10: internal request after an external reset clears the flag
    push(1'b0, 2'b10, 16, 8, "R4 R10 after external");
    request(2'b10);
    repeat (40) @(negedge clk);

    check(exp_q.size() == 0, "scoreboard drained", exp_q.size(), 0);
    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule